// File: doc/BRIEF.md
# Segmented Address Translator

This block sits between a 16-bit processor's 24-bit byte address bus and the rest of the system. It holds a table of 512 segment descriptors, one for each 4 KB page of a 2 MB logical window at the bottom of the address space. When translation applies, the page index selects a descriptor. The descriptor's 12-bit physical segment number then replaces the top twelve address bits, and the page offset passes through unchanged.

Translation always applies to user-mode accesses inside the logical window. Supervisor accesses inside the window are translated only while the map-enable input is high. Each descriptor carries three control bits: write-protect, invalid and not-resident. These bits, together with the processor mode, drive four fault outputs and a qualified address strobe. Downstream memory may act only on that qualified strobe.

A host port gives word read and write access to the descriptor table through a 1 KB byte window. A write lands at the clock edge and is used by the next translated access. A read returns its data one cycle after the request.

Top module: `seg_xlate_top`

## Requirements
- R1: `xl_mapped` is 1 when `cpu_addr[23:21]` is 0 and either `cpu_super` is 0 or `map_en` is 1. It is 0 in every other case.
- R2: While `xl_mapped` is 1, `xl_addr[23:12]` equals bits 11..0 of the descriptor selected by `cpu_addr[20:12]`, and `xl_addr[11:0]` equals `cpu_addr[11:0]`.
- R3: While `xl_mapped` is 0, `xl_addr` equals `cpu_addr`.
- R4: `flt_range` is 1 exactly when `cpu_as` is 1, `cpu_super` is 0 and `cpu_addr[23:21]` is nonzero.
- R5: `flt_wprot` is 1 exactly when `cpu_as` is 1, `xl_mapped` is 1, `cpu_rd` is 0 (a write) and descriptor bit 14 (write-protect) is 1.
- R6: `flt_inval` is 1 exactly when `cpu_as` is 1, `xl_mapped` is 1 and descriptor bit 13 (invalid) is 1.
- R7: `flt_absent` is 1 exactly when `cpu_as` is 1, `xl_mapped` is 1 and descriptor bit 12 (not resident) is 1.
- R8: `xl_as` is 1 in two cases, and only these. The first is when `cpu_as` is 1, the access is mapped, descriptor bits 13 and 12 are both 0, and either `cpu_rd` is 1 or bit 14 is 0. The second is when `cpu_as` is 1, `cpu_super` is 1 and `xl_mapped` is 0.
- R9: While `cpu_as` is 0, `xl_as` and all four fault outputs are 0.
- R10: A host write (`hst_wr`) to byte address 0xEFF800 + 2*i stores all 16 bits of `hst_wdata` in descriptor i. A host read (`hst_rd`) of that address presents descriptor i on `hst_rdata` one clock later. `hst_rdata` holds its value in cycles without a read.
- R11: A host write outside 0xEFF800..0xEFFBFF changes no descriptor. A host read outside that range returns 0.
- R12: After reset every descriptor reads 0 and `hst_rdata` is 0.
- R13: A descriptor written at a clock edge is used by any translation presented after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 24 | Processor byte address |
| cpu_as | input | 1 | Processor address strobe |
| cpu_rd | input | 1 | 1 = read, 0 = write |
| cpu_super | input | 1 | 1 = supervisor mode |
| map_en | input | 1 | Supervisor translation enable |
| hst_wr | input | 1 | Host descriptor write |
| hst_rd | input | 1 | Host descriptor read |
| hst_addr | input | 24 | Host byte address |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data (registered) |
| xl_addr | output | 24 | Translated address |
| xl_mapped | output | 1 | Translation applied |
| xl_as | output | 1 | Qualified address strobe |
| flt_range | output | 1 | User access outside logical window |
| flt_wprot | output | 1 | Write to protected segment |
| flt_inval | output | 1 | Access to invalid segment |
| flt_absent | output | 1 | Access to non-resident segment |

## Verification
A corrupted descriptor shows up on the next strobed access to its page. It appears as a wrong upper half of `xl_addr` or as a spurious or missing fault, in the same cycle as the access. The same corruption also appears on `hst_rdata` one clock after a host read. A wrong mode decision shows up immediately as `xl_mapped` disagreeing with the mode and flag inputs. Because every descriptor is rewritten at random and then probed through both ports, a stuck or misrouted table bit surfaces within a few hundred cycles.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   // Decoded control bits of one descriptor
   typedef struct packed {
      logic wprot;
      logic inval;
      logic absent;
   } seg_ctl_t;

   // Result of the fault decode for one access
   typedef struct packed {
      logic range;
      logic wprot;
      logic inval;
      logic absent;
   } seg_flt_t;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
   parameter int ADDR_W    = 24,
   parameter int IDX_W     = 9,
   parameter int ENTRY_W   = 16,
   parameter int SEG_W     = 12,
   parameter logic [23:0] WIN_BASE = 24'hEFF800,
   parameter bit KEEP_SPARE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic               rd_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [ENTRY_W-1:0] wdata_i,
   output logic [ENTRY_W-1:0] rdata_o,
   input  logic [IDX_W-1:0]   lk_idx_i,
   output logic [ENTRY_W-1:0] lk_entry_o
);
   localparam int ENTRIES = 1 << IDX_W;
   localparam int USED_W  = SEG_W + 3;

   logic [ENTRY_W-1:0] mem [ENTRIES];
   logic               hit;
   logic [IDX_W-1:0]   hidx;
   logic [ENTRY_W-1:0] wval;

   // Window is aligned, so only the bits above the word index are compared
   assign hit  = (addr_i[ADDR_W-1:IDX_W+1] == WIN_BASE[ADDR_W-1:IDX_W+1]);
   assign hidx = addr_i[IDX_W:1];

   generate
      if (KEEP_SPARE || (ENTRY_W == USED_W)) begin : g_full
         assign wval = wdata_i;
      end else begin : g_trim
         assign wval = {{(ENTRY_W-USED_W){1'b0}}, wdata_i[USED_W-1:0]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
      end else if (wr_i && hit) begin
         mem[hidx] <= wval;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_o <= '0;
      else if (rd_i)  rdata_o <= hit ? mem[hidx] : '0;
   end

   assign lk_entry_o = mem[lk_idx_i];
endmodule

// File: rtl/seg_mode.sv
module seg_mode #(
   parameter int ADDR_W = 24,
   parameter int SPACE_W = 21
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              super_i,
   input  logic              flag_i,
   output logic              in_space_o,
   output logic              mapped_o
);
   assign in_space_o = (addr_i[ADDR_W-1:SPACE_W] == '0);
   assign mapped_o   = in_space_o && (!super_i || flag_i);
endmodule

// File: rtl/seg_fault_dec.sv
module seg_fault_dec
   import seg_xlate_pkg::*;
(
   input  logic     as_i,
   input  logic     rd_i,
   input  logic     super_i,
   input  logic     in_space_i,
   input  logic     mapped_i,
   input  seg_ctl_t ctl_i,
   output seg_flt_t flt_o,
   output logic     vas_o
);
   logic map_ok;

   always_comb begin
      flt_o.range  = as_i && !super_i && !in_space_i;
      flt_o.wprot  = as_i && mapped_i && !rd_i && ctl_i.wprot;
      flt_o.inval  = as_i && mapped_i && ctl_i.inval;
      flt_o.absent = as_i && mapped_i && ctl_i.absent;
      map_ok = mapped_i && !ctl_i.inval && !ctl_i.absent && (rd_i || !ctl_i.wprot);
      vas_o  = as_i && (map_ok || (super_i && !mapped_i));
   end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int PAGE_W    = 12,
   parameter int IDX_W     = 9,
   parameter int ENTRY_W   = 16,
   parameter logic [23:0] WIN_BASE = 24'hEFF800,
   parameter bit KEEP_SPARE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic               cpu_as,
   input  logic               cpu_rd,
   input  logic               cpu_super,
   input  logic               map_en,
   input  logic               hst_wr,
   input  logic               hst_rd,
   input  logic [ADDR_W-1:0]  hst_addr,
   input  logic [ENTRY_W-1:0] hst_wdata,
   output logic [ENTRY_W-1:0] hst_rdata,
   output logic [ADDR_W-1:0]  xl_addr,
   output logic               xl_mapped,
   output logic               xl_as,
   output logic               flt_range,
   output logic               flt_wprot,
   output logic               flt_inval,
   output logic               flt_absent
);
   localparam int SEG_W   = ADDR_W - PAGE_W;
   localparam int SPACE_W = PAGE_W + IDX_W;
   localparam int WIN_B   = 2 << IDX_W;

   // Elaboration-time checks
   generate
      if (ENTRY_W < SEG_W + 3) begin : g_bad_entry
         $error("ENTRY_W too narrow for segment number and control bits");
      end
      if (SPACE_W >= ADDR_W) begin : g_bad_space
         $error("logical space must be smaller than address space");
      end
      if ((WIN_BASE % WIN_B) != 0) begin : g_bad_base
         $error("WIN_BASE must be aligned to the table window size");
      end
   endgenerate

   logic [ENTRY_W-1:0] entry;
   logic               in_space;
   logic               mapped;
   seg_ctl_t           ctl;
   seg_flt_t           flt;

   seg_table #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W), .SEG_W(SEG_W),
      .WIN_BASE(WIN_BASE), .KEEP_SPARE(KEEP_SPARE)
   ) u_tab (
      .clk(clk), .rst_n(rst_n),
      .wr_i(hst_wr), .rd_i(hst_rd), .addr_i(hst_addr),
      .wdata_i(hst_wdata), .rdata_o(hst_rdata),
      .lk_idx_i(cpu_addr[SPACE_W-1:PAGE_W]), .lk_entry_o(entry)
   );

   seg_mode #(.ADDR_W(ADDR_W), .SPACE_W(SPACE_W)) u_mode (
      .addr_i(cpu_addr), .super_i(cpu_super), .flag_i(map_en),
      .in_space_o(in_space), .mapped_o(mapped)
   );

   assign ctl.wprot  = entry[SEG_W+2];
   assign ctl.inval  = entry[SEG_W+1];
   assign ctl.absent = entry[SEG_W];

   seg_fault_dec u_flt (
      .as_i(cpu_as), .rd_i(cpu_rd), .super_i(cpu_super),
      .in_space_i(in_space), .mapped_i(mapped), .ctl_i(ctl),
      .flt_o(flt), .vas_o(xl_as)
   );

   assign xl_addr    = mapped ? {entry[SEG_W-1:0], cpu_addr[PAGE_W-1:0]} : cpu_addr;
   assign xl_mapped  = mapped;
   assign flt_range  = flt.range;
   assign flt_wprot  = flt.wprot;
   assign flt_inval  = flt.inval;
   assign flt_absent = flt.absent;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int ADDR_W  = 24,
   parameter int ENTRY_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  cpu_addr,
   input logic               cpu_as,
   input logic               cpu_rd,
   input logic               cpu_super,
   input logic               map_en,
   input logic               hst_wr,
   input logic               hst_rd,
   input logic [ADDR_W-1:0]  hst_addr,
   input logic [ENTRY_W-1:0] hst_wdata,
   input logic [ENTRY_W-1:0] hst_rdata,
   input logic [ADDR_W-1:0]  xl_addr,
   input logic               xl_mapped,
   input logic               xl_as,
   input logic               flt_range,
   input logic               flt_wprot,
   input logic               flt_inval,
   input logic               flt_absent
);
   logic hst_in_win;
   assign hst_in_win = (hst_addr[23:10] == 14'h3BFE);

   p_high_unmapped_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[23:21] != 3'b000) |-> !xl_mapped);
   p_user_mapped_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_super && cpu_addr[23:21] == 3'b000) |-> xl_mapped);
   p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xl_mapped |-> (xl_addr[11:0] == cpu_addr[11:0]));
   p_unmapped_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !xl_mapped |-> (xl_addr == cpu_addr));
   p_range_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      flt_range |-> (!xl_as && !xl_mapped));
   p_wprot_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flt_wprot |-> (!cpu_rd && xl_mapped));
   p_inval_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flt_inval |-> !xl_as);
   p_absent_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flt_absent |-> !xl_as);
   p_super_flat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_as && cpu_super && !xl_mapped) |-> xl_as);
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_as |-> !(xl_as || flt_range || flt_wprot || flt_inval || flt_absent));
   p_readback_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_rd && !hst_wr && hst_in_win && $past(hst_wr) && $past(hst_addr) == hst_addr)
      |=> (hst_rdata == $past(hst_wdata, 2)));
   p_outside_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_rd && !hst_in_win) |=> (hst_rdata == '0));
   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !hst_rd |=> $stable(hst_rdata));
endmodule

bind seg_xlate_top seg_xlate_chk #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_as(cpu_as),
   .cpu_rd(cpu_rd), .cpu_super(cpu_super), .map_en(map_en),
   .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
   .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .xl_addr(xl_addr),
   .xl_mapped(xl_mapped), .xl_as(xl_as), .flt_range(flt_range),
   .flt_wprot(flt_wprot), .flt_inval(flt_inval), .flt_absent(flt_absent)
);

// File: tb/sim_seg_xlate_top.sv
`timescale 1ns/1ps
module sim_seg_xlate_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] cpu_addr = '0;
   logic        cpu_as = 1'b0, cpu_rd = 1'b1, cpu_super = 1'b0, map_en = 1'b0;
   logic        hst_wr = 1'b0, hst_rd = 1'b0;
   logic [23:0] hst_addr = '0;
   logic [15:0] hst_wdata = '0;
   logic [15:0] hst_rdata;
   logic [23:0] xl_addr;
   logic        xl_mapped, xl_as, flt_range, flt_wprot, flt_inval, flt_absent;

   int checks = 0;
   int fails  = 0;
   logic [15:0] shadow [512];

   always #4 clk = ~clk;

   seg_xlate_top u0 (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_as(cpu_as),
      .cpu_rd(cpu_rd), .cpu_super(cpu_super), .map_en(map_en),
      .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
      .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .xl_addr(xl_addr),
      .xl_mapped(xl_mapped), .xl_as(xl_as), .flt_range(flt_range),
      .flt_wprot(flt_wprot), .flt_inval(flt_inval), .flt_absent(flt_absent)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit in_win(input logic [23:0] a);
      return (a >= 24'hEFF800) && (a <= 24'hEFFBFF);
   endfunction

   task automatic host_write(input logic [23:0] a, input logic [15:0] d);
      @(negedge clk);
      hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
      @(negedge clk);
      hst_wr = 1'b0;
      if (in_win(a)) shadow[a[9:1]] = d;
   endtask

   task automatic host_read(input logic [23:0] a, input string req);
      logic [15:0] e;
      @(negedge clk);
      hst_rd = 1'b1; hst_addr = a;
      @(negedge clk);
      hst_rd = 1'b0;
      e = in_win(a) ? shadow[a[9:1]] : 16'h0;
      chk(req, {16'h0, hst_rdata}, {16'h0, e});
   endtask

   // Drive an access and compare every output with the rule-based model
   task automatic probe(input logic [23:0] a, input bit as, input bit rd,
                        input bit sup, input bit fl);
      logic [15:0] ent;
      bit m, wp, iv, ab, okm;
      logic [23:0] ea;
      @(negedge clk);
      cpu_addr = a; cpu_as = as; cpu_rd = rd; cpu_super = sup; map_en = fl;
      #1;
      ent = shadow[a[20:12]];
      m   = (a[23:21] == 3'b000) && (!sup || fl);
      wp  = ent[14]; iv = ent[13]; ab = ent[12];
      ea  = m ? {ent[11:0], a[11:0]} : a;
      okm = m && !iv && !ab && (rd || !wp);
      chk("R1 mapped", {31'h0, xl_mapped}, {31'h0, m});
      chk(m ? "R2 translated address" : "R3 flat address", {8'h0, xl_addr}, {8'h0, ea});
      if (!as) begin
         chk("R9 idle outputs",
             {27'h0, xl_as, flt_range, flt_wprot, flt_inval, flt_absent}, 32'h0);
      end else begin
         chk("R4 range fault", {31'h0, flt_range}, {31'h0, (!sup && a[23:21] != 3'b000)});
         chk("R5 write-protect fault", {31'h0, flt_wprot}, {31'h0, (m && !rd && wp)});
         chk("R6 invalid fault", {31'h0, flt_inval}, {31'h0, (m && iv)});
         chk("R7 absent fault", {31'h0, flt_absent}, {31'h0, (m && ab)});
         chk("R8 qualified strobe", {31'h0, xl_as}, {31'h0, (okm || (sup && !m))});
      end
   endtask

   task automatic finish_run;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      for (int i = 0; i < 512; i++) shadow[i] = 16'h0;
      r = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: reset state
      chk("R12 rdata after reset", {16'h0, hst_rdata}, 32'h0);
      host_read(24'hEFF800, "R12 entry 0 after reset");
      host_read(24'hEFFBFE, "R12 entry 511 after reset");
      probe(24'h000000, 1'b0, 1'b1, 1'b0, 1'b0);

      // R10 / R13: write then use immediately
      host_write(24'hEFF800 + 24'd6, 16'h0ABC);
      probe(24'h003456, 1'b1, 1'b1, 1'b0, 1'b0);
      chk("R13 new descriptor used", {8'h0, xl_addr}, {8'h0, 24'hABC456});
      host_read(24'hEFF806, "R10 readback");
      host_write(24'hEFF806, 16'hC123);
      chk("R10 rdata holds without read", {16'h0, hst_rdata}, 32'h0ABC);
      host_read(24'hEFF806, "R10 readback spare bit");
      probe(24'h003000, 1'b1, 1'b1, 1'b0, 1'b0);
      probe(24'h003002, 1'b1, 1'b0, 1'b0, 1'b0);
      chk("R5 protected write faults", {31'h0, flt_wprot}, 32'h1);

      // R11: edges of the window
      host_write(24'hEFF7FE, 16'h7FFF);
      host_write(24'hEFFC00, 16'h7FFF);
      host_read(24'hEFF800, "R11 entry 0 untouched");
      host_read(24'hEFFBFE, "R11 entry 511 untouched");
      host_read(24'hEFF7FE, "R11 outside read zero");
      host_read(24'hEFFC00, "R11 outside read zero high");

      // R1/R4/R8 mode corners
      probe(24'h1FFFFF, 1'b1, 1'b1, 1'b1, 1'b0);
      probe(24'h1FFFFF, 1'b1, 1'b1, 1'b1, 1'b1);
      probe(24'h200000, 1'b1, 1'b1, 1'b0, 1'b1);
      probe(24'h200000, 1'b1, 1'b0, 1'b1, 1'b1);
      probe(24'hE00000, 1'b0, 1'b1, 1'b0, 1'b0);

      // Constrained random: fill table, then mixed accesses and rewrites
      for (int i = 0; i < 600; i++) begin
         r = $urandom();
         host_write(24'hEFF800 + {13'h0, r[8:0], 1'b0}, r[31:16]);
      end
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] a, k;
         a = $urandom();
         k = $urandom();
         if (k[3:0] == 4'h0) begin
            host_write(24'hEFF800 + {13'h0, a[8:0], 1'b0}, k[31:16]);
         end else if (k[3:0] == 4'h1) begin
            host_read(24'hEFF800 + {13'h0, a[8:0], 1'b0}, "R10 random readback");
         end else begin
            // bias toward the logical window
            if (k[6:4] != 3'b000) a[23:21] = 3'b000;
            probe(a[23:0], k[7] | k[8], k[9], k[10], k[11]);
         end
      end
      finish_run();
   end
endmodule